// File: doc/BRIEF.md
# Wall-Following Maze Walker Controller

This block is the steering brain of a small agent that walks through a maze while keeping a wall on its right-hand side. Two contact sensors, one on each side of the agent's front, report whether they are pressing against a wall. From these the controller issues three actuator commands: step forward, veer left a little and veer right a little. The machine is of the Moore type. The commands follow only from the registered state, so a sensor change affects the actuators one clock edge later.

There are five behavioural states, each with a fixed 3-bit code. The machine starts in a seek state and walks straight ahead until a sensor touches something. It then pivots left until only the right sensor is in contact. From there it hugs the wall. When the right sensor loses contact it swings right to find the wall again, and it keeps swinging right across a gap until it makes contact. The three spare codes are never entered in normal operation. If one is held after an upset, the actuators stay idle for that cycle and the next clock returns the machine to seek. The state code is also driven out on a port so that the surrounding logic can see it.

Top module: `wall_follow_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes seek (code 000). After reset, `mode_o` reads 000 and only `step_fwd_o` is high.
- R2: Each state has a fixed code on `mode_o` and a fixed set of actuator commands (order fwd/left/right). Seek is 000 with fwd only. Pivot is 001 with left only. Hug is 010 with fwd and left. Reacquire is 011 with fwd and right. Gap is 100 with fwd and right.
- R3: In seek, the next state is seek when both sensors are low, and pivot when either sensor is high.
- R4: In pivot and in hug, a high left sensor leads to pivot. Otherwise a high right sensor leads to hug, and two low sensors lead to reacquire.
- R5: In reacquire and in gap, a high right sensor leads to hug and a low right sensor leads to gap. The left sensor has no effect in these states.
- R6: In the spare codes 101, 110 and 111, all three actuator commands are low, and the next rising edge moves the state to seek (000).
- R7: The actuator outputs and `mode_o` do not change when the sensor inputs change between clock edges.
- R8: For the five used codes, with bits X (MSB), Y and Z, `veer_right_o` equals X OR (Y AND Z).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ant_left_i | input | 1 | Left sensor, high while it touches a wall |
| ant_right_i | input | 1 | Right sensor, high while it touches a wall |
| step_fwd_o | output | 1 | Command to take a forward step |
| veer_left_o | output | 1 | Command to turn slightly left |
| veer_right_o | output | 1 | Command to turn slightly right |
| mode_o | output | 3 | Current state code |

## Verification
The spare codes are the hard case. No sequence of sensor values can reach them from reset, so the recovery path in R6 cannot be reached from the ports at all. The bench therefore overrides the state register with each spare code at a falling edge. It checks that the actuators are idle, releases the override and checks that the following rising edge lands in seek. Each used state is reached by a short sensor sequence from reset and then tried with all four sensor combinations. This separates reacquire from gap, which have the same actuator commands and can only be told apart through `mode_o`.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int STATE_W = 3;
  typedef logic [STATE_W-1:0] state_t;

  localparam state_t ST_SEEK  = 3'b000;
  localparam state_t ST_PIVOT = 3'b001;
  localparam state_t ST_HUG   = 3'b010;
  localparam state_t ST_REACQ = 3'b011;
  localparam state_t ST_GAP   = 3'b100;

  typedef struct packed {
    logic fwd;
    logic left;
    logic right;
  } act_t;
endpackage

// File: rtl/wf_next_state.sv
module wf_next_state
  import wf_pkg::*;
(
  input  state_t cur_i,
  input  logic   left_i,
  input  logic   right_i,
  output state_t nxt_o
);
  always_comb begin
    case (cur_i)
      ST_SEEK:  nxt_o = (left_i || right_i) ? ST_PIVOT : ST_SEEK;
      ST_PIVOT,
      ST_HUG: begin
        if (left_i)       nxt_o = ST_PIVOT;
        else if (right_i) nxt_o = ST_HUG;
        else              nxt_o = ST_REACQ;
      end
      ST_REACQ,
      ST_GAP:   nxt_o = right_i ? ST_HUG : ST_GAP;
      default:  nxt_o = ST_SEEK;
    endcase
  end
endmodule

// File: rtl/wf_state_reg.sv
module wf_state_reg
  import wf_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_t nxt_i,
  output state_t state_q
);
  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_SEEK;
    else     state_q <= nxt_i;
  end
endmodule

// File: rtl/wf_action_decode.sv
module wf_action_decode
  import wf_pkg::*;
(
  input  state_t state_i,
  output act_t   act_o
);
  always_comb begin
    case (state_i)
      ST_SEEK:  act_o = '{fwd: 1'b1, left: 1'b0, right: 1'b0};
      ST_PIVOT: act_o = '{fwd: 1'b0, left: 1'b1, right: 1'b0};
      ST_HUG:   act_o = '{fwd: 1'b1, left: 1'b1, right: 1'b0};
      ST_REACQ: act_o = '{fwd: 1'b1, left: 1'b0, right: 1'b1};
      ST_GAP:   act_o = '{fwd: 1'b1, left: 1'b0, right: 1'b1};
      default:  act_o = '{fwd: 1'b0, left: 1'b0, right: 1'b0};
    endcase
  end
endmodule

// File: rtl/wall_follow_ctrl.sv
module wall_follow_ctrl
  import wf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ant_left_i,
  input  logic               ant_right_i,
  output logic               step_fwd_o,
  output logic               veer_left_o,
  output logic               veer_right_o,
  output logic [STATE_W-1:0] mode_o
);
  state_t state_q;
  state_t nxt_s;
  act_t   act_s;

  wf_next_state u_next (
    .cur_i   (state_q),
    .left_i  (ant_left_i),
    .right_i (ant_right_i),
    .nxt_o   (nxt_s)
  );

  wf_state_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .nxt_i   (nxt_s),
    .state_q (state_q)
  );

  wf_action_decode u_dec (
    .state_i (state_q),
    .act_o   (act_s)
  );

  assign step_fwd_o   = act_s.fwd;
  assign veer_left_o  = act_s.left;
  assign veer_right_o = act_s.right;
  assign mode_o       = state_q;
endmodule

// File: rtl/wf_checker.sv
module wf_checker
  import wf_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               ant_left_i,
  input logic               ant_right_i,
  input logic               step_fwd_o,
  input logic               veer_left_o,
  input logic               veer_right_o,
  input logic [STATE_W-1:0] mode_o
);
  logic spare;
  assign spare = (mode_o == 3'b101) || (mode_o == 3'b110) || (mode_o == 3'b111);

  p_reset_seek_r1: assert property (@(posedge clk) rst |=> (mode_o == ST_SEEK));

  p_no_opposed_turn_r2: assert property (@(posedge clk) disable iff (rst)
    !(veer_left_o && veer_right_o));

  p_seek_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == ST_SEEK && !ant_left_i && !ant_right_i) |=> (mode_o == ST_SEEK));

  p_seek_touch_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == ST_SEEK && (ant_left_i || ant_right_i)) |=> (mode_o == ST_PIVOT));

  p_left_pivot_r4: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == ST_PIVOT || mode_o == ST_HUG) && ant_left_i) |=> (mode_o == ST_PIVOT));

  p_right_hug_r5: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == ST_REACQ || mode_o == ST_GAP) && ant_right_i) |=> (mode_o == ST_HUG));

  p_spare_idle_r6: assert property (@(posedge clk) disable iff (rst)
    spare |-> !(step_fwd_o || veer_left_o || veer_right_o));

  p_spare_exit_r6: assert property (@(posedge clk) disable iff (rst)
    spare |=> (mode_o == ST_SEEK));

  p_right_eq_r8: assert property (@(posedge clk) disable iff (rst)
    !spare |-> (veer_right_o == (mode_o[2] | (mode_o[1] & mode_o[0]))));
endmodule

bind wall_follow_ctrl wf_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .ant_left_i   (ant_left_i),
  .ant_right_i  (ant_right_i),
  .step_fwd_o   (step_fwd_o),
  .veer_left_o  (veer_left_o),
  .veer_right_o (veer_right_o),
  .mode_o       (mode_o)
);

// File: tb/sim_wall_follow_ctrl.sv
`timescale 1ns/1ps
module sim_wall_follow_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b0;
  logic l = 1'b0;
  logic r = 1'b0;
  logic fwd, tl, tr;
  logic [2:0] mode;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wall_follow_ctrl u0 (
    .clk(clk), .rst(rst), .ant_left_i(l), .ant_right_i(r),
    .step_fwd_o(fwd), .veer_left_o(tl), .veer_right_o(tr), .mode_o(mode)
  );

  // Expected next code, built from R3, R4, R5 and R6
  function automatic logic [2:0] exp_next(input logic [2:0] s, input logic li, input logic ri);
    case (s)
      3'b000: return (li | ri) ? 3'b001 : 3'b000;
      3'b001, 3'b010: return li ? 3'b001 : (ri ? 3'b010 : 3'b011);
      3'b011, 3'b100: return ri ? 3'b010 : 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  // Expected {fwd,left,right}, built from R2 and R6
  function automatic logic [2:0] exp_act(input logic [2:0] s);
    case (s)
      3'b000: return 3'b100;
      3'b001: return 3'b010;
      3'b010: return 3'b110;
      3'b011, 3'b100: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic li, input logic ri);
    @(negedge clk);
    l = li; r = ri;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; l = 1'b0; r = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Walk from reset to a used state by sensor stimulus only
  task automatic goto_state(input logic [2:0] s);
    do_reset();
    if (s != 3'b000) drive(1'b0, 1'b1);
    if (s == 3'b010 || s == 3'b011 || s == 3'b100) drive(1'b0, 1'b1);
    if (s == 3'b011 || s == 3'b100) drive(1'b0, 1'b0);
    if (s == 3'b100) drive(1'b0, 1'b0);
  endtask

  task automatic test_reset();
    do_reset();
    #1;
    chk("R1 reset state", {mode, fwd, tl, tr}, {3'b000, 3'b100});
  endtask

  task automatic test_all_states();
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic [2:0] st;
        logic [2:0] nx;
        st = 3'(s);
        goto_state(st);
        chk("R2 state code and commands", {mode, fwd, tl, tr}, {st, exp_act(st)});
        chk("R8 right command from state bits", {5'b0, tr}, {5'b0, st[2] | (st[1] & st[0])});
        nx = exp_next(st, c[1], c[0]);
        drive(c[1], c[0]);
        if (s == 0) chk("R3 seek transition", {mode, fwd, tl, tr}, {nx, exp_act(nx)});
        else if (s < 3) chk("R4 pivot/hug transition", {mode, fwd, tl, tr}, {nx, exp_act(nx)});
        else chk("R5 reacquire/gap transition", {mode, fwd, tl, tr}, {nx, exp_act(nx)});
      end
    end
  endtask

  task automatic test_spare();
    for (int k = 5; k < 8; k++) begin
      logic [2:0] sp;
      sp = 3'(k);
      goto_state(3'b010);
      @(negedge clk);
      l = 1'b0; r = 1'b1;
      force u0.u_reg.state_q = sp;
      #1;
      chk("R6 spare code idles actuators", {mode, fwd, tl, tr}, {sp, 3'b000});
      release u0.u_reg.state_q;
      @(posedge clk);
      #1;
      chk("R6 spare code returns to seek", {mode, fwd, tl, tr}, {3'b000, 3'b100});
    end
  endtask

  task automatic test_no_comb_path();
    goto_state(3'b010);
    @(negedge clk);
    l = 1'b1; r = 1'b1;
    #1;
    chk("R7 outputs steady with sensors both high", {mode, fwd, tl, tr}, {3'b010, 3'b110});
    l = 1'b0; r = 1'b0;
    #0.5;
    chk("R7 outputs steady with sensors both low", {mode, fwd, tl, tr}, {3'b010, 3'b110});
    goto_state(3'b011);
    @(negedge clk);
    l = 1'b1; r = 1'b0;
    #1;
    chk("R7 reacquire steady under left contact", {mode, fwd, tl, tr}, {3'b011, 3'b101});
  endtask

  initial begin
    test_reset();
    test_all_states();
    test_spare();
    test_no_comb_path();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule